// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block moves data between two wide ports, A and B. Each direction of travel (A toward B, B toward A) owns a bank of storage that either follows its source port or holds the last captured word. It also owns three active-low controls: a direction enable, a capture enable and a drive enable. The word is split into halves, each with its own full control set, so one block can serve as two narrow transceivers. A gang input makes the half-0 controls govern the whole word, so the halves act as one wide path.

Storage is modelled synchronously so that no latches are inferred. On every rising clock edge, a bank whose direction enable and capture enable are both low loads its source port. Otherwise the bank keeps its value. A rise on either enable therefore puts the bank into storage mode. Each port shows its bank's content on a data output at all times. A per-half drive flag tells a pad wrapper when that data should actually be driven. When the flag is low, the port is high impedance.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: While rst_n is low, both storage banks are cleared to zero, and every drive flag (a_oe, b_oe) is low.
- R2: When ab_ce_n and ab_le_n of a governing half are both low at a rising clock edge, that half of the A-to-B bank loads a_in. The value shows on b_out just after that edge.
- R3: When ab_ce_n or ab_le_n of a governing half is high at a rising edge, that half of the A-to-B bank keeps its value. This covers a rise of the capture enable and a rise of the direction enable.
- R4: b_oe for a half is high exactly when the governing ab_ce_n and ab_oe_n are both low, with no clock delay. Otherwise it is low and the B side of that half is high impedance.
- R5: The B-to-A direction follows R2 to R4 with ba_ce_n, ba_le_n and ba_oe_n, loading b_in into its bank and showing it on a_out with drive flag a_oe.
- R6: A-to-B controls have no effect on the B-to-A bank or on a_oe, and B-to-A controls have no effect on the A-to-B bank or on b_oe.
- R7: With gang_i low, control index h governs only data bits [18h+17:18h] and drive flag index h. Control index 0 governs bits [17:0].
- R8: With gang_i high, control index 0 governs all 36 bits and both drive flags, and the index-1 controls are ignored.
- R9: Dropping and restoring a drive enable leaves the stored word unchanged. After the drive flag rises again, the port shows the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples all controls |
| rst_n | input | 1 | Asynchronous active-low reset |
| gang_i | input | 1 | High: half-0 controls drive the whole word |
| a_in | input | 36 | Data received on the A port |
| b_in | input | 36 | Data received on the B port |
| ab_ce_n | input | 2 | A-to-B direction enable per half, active low |
| ab_le_n | input | 2 | A-to-B capture enable per half, active low |
| ab_oe_n | input | 2 | B drive enable per half, active low |
| ba_ce_n | input | 2 | B-to-A direction enable per half, active low |
| ba_le_n | input | 2 | B-to-A capture enable per half, active low |
| ba_oe_n | input | 2 | A drive enable per half, active low |
| a_out | output | 36 | B-to-A bank content for the A port |
| a_oe | output | 2 | A port drive flag per half |
| b_out | output | 36 | A-to-B bank content for the B port |
| b_oe | output | 2 | B port drive flag per half |

## Verification
The bench builds the block with its default of two 18-bit halves. This makes the split-control and ganged cases reachable: a word can be loaded into one half while the other half holds, and ganging is shown by toggling half-1 controls with no visible effect. Data patterns differ per half, so a control that steers the wrong bit range shows up as a mismatch. Both directions are exercised together so that leakage from one direction into the other is seen.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    typedef struct packed {
        logic ce_n;
        logic le_n;
        logic oe_n;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{ce_n: 1'b1, le_n: 1'b1, oe_n: 1'b1};
endpackage

// File: rtl/xcvr_ctrl_sel.sv
module xcvr_ctrl_sel
    import xcvr_pkg::*;
#(
    parameter int NUM_HALVES = 2
) (
    input  logic                  gang_i,
    input  logic [NUM_HALVES-1:0] ce_n_i,
    input  logic [NUM_HALVES-1:0] le_n_i,
    input  logic [NUM_HALVES-1:0] oe_n_i,
    output ctrl_t [NUM_HALVES-1:0] ctrl_o
);
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        localparam int SRC = (h == 0) ? 0 : h;
        always_comb begin
            if (gang_i) begin
                ctrl_o[h].ce_n = ce_n_i[0];
                ctrl_o[h].le_n = le_n_i[0];
                ctrl_o[h].oe_n = oe_n_i[0];
            end else begin
                ctrl_o[h].ce_n = ce_n_i[SRC];
                ctrl_o[h].le_n = le_n_i[SRC];
                ctrl_o[h].oe_n = oe_n_i[SRC];
            end
        end
    end
endmodule

// File: rtl/xcvr_dir_lane.sv
module xcvr_dir_lane
    import xcvr_pkg::*;
#(
    parameter int HALF_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl_i,
    input  logic [HALF_W-1:0] d_i,
    output logic [HALF_W-1:0] q_o,
    output logic              oe_o
);
    typedef struct packed {
        logic [HALF_W-1:0] data;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic     capture;

    always_comb begin
        st_d    = st_q;
        capture = !ctrl_i.ce_n && !ctrl_i.le_n;
        if (capture) begin
            st_d.data = d_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o  = st_q.data;
    assign oe_o = rst_n && !ctrl_i.ce_n && !ctrl_i.oe_n;

    // R1: storage is zero one edge into reset
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (q_o == '0));

    // R2: a capture edge loads the source word
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_i.ce_n && !ctrl_i.le_n) |=> (q_o == $past(d_i)));

    // R3: storage mode keeps the word
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i.ce_n || ctrl_i.le_n) |=> $stable(q_o));
endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr
    import xcvr_pkg::*;
#(
    parameter int HALF_W     = 18,
    parameter int NUM_HALVES = 2,
    localparam int W         = HALF_W * NUM_HALVES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  gang_i,
    input  logic [W-1:0]          a_in,
    input  logic [W-1:0]          b_in,
    input  logic [NUM_HALVES-1:0] ab_ce_n,
    input  logic [NUM_HALVES-1:0] ab_le_n,
    input  logic [NUM_HALVES-1:0] ab_oe_n,
    input  logic [NUM_HALVES-1:0] ba_ce_n,
    input  logic [NUM_HALVES-1:0] ba_le_n,
    input  logic [NUM_HALVES-1:0] ba_oe_n,
    output logic [W-1:0]          a_out,
    output logic [NUM_HALVES-1:0] a_oe,
    output logic [W-1:0]          b_out,
    output logic [NUM_HALVES-1:0] b_oe
);
    ctrl_t [NUM_HALVES-1:0] ab_ctrl;
    ctrl_t [NUM_HALVES-1:0] ba_ctrl;

    xcvr_ctrl_sel #(.NUM_HALVES(NUM_HALVES)) i_ab_sel (
        .gang_i (gang_i),
        .ce_n_i (ab_ce_n),
        .le_n_i (ab_le_n),
        .oe_n_i (ab_oe_n),
        .ctrl_o (ab_ctrl)
    );

    xcvr_ctrl_sel #(.NUM_HALVES(NUM_HALVES)) i_ba_sel (
        .gang_i (gang_i),
        .ce_n_i (ba_ce_n),
        .le_n_i (ba_le_n),
        .oe_n_i (ba_oe_n),
        .ctrl_o (ba_ctrl)
    );

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        localparam int LO = h * HALF_W;

        xcvr_dir_lane #(.HALF_W(HALF_W)) i_ab_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctrl_i (ab_ctrl[h]),
            .d_i    (a_in[LO +: HALF_W]),
            .q_o    (b_out[LO +: HALF_W]),
            .oe_o   (b_oe[h])
        );

        xcvr_dir_lane #(.HALF_W(HALF_W)) i_ba_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctrl_i (ba_ctrl[h]),
            .d_i    (b_in[LO +: HALF_W]),
            .q_o    (a_out[LO +: HALF_W]),
            .oe_o   (a_oe[h])
        );

        // R4: the B side is driven only with its own direction enabled
        a_r4_b_drive_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
            (!gang_i && b_oe[h]) |-> (!ab_ce_n[h] && !ab_oe_n[h]));

        // R5: the A side is driven only with its own direction enabled
        a_r5_a_drive_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
            (!gang_i && a_oe[h]) |-> (!ba_ce_n[h] && !ba_oe_n[h]));

        // R8: under gang every half copies half 0
        a_r8_gang_flags: assert property (@(posedge clk) disable iff (!rst_n)
            gang_i |-> ((b_oe[h] == b_oe[0]) && (a_oe[h] == a_oe[0])));
    end

    // R1: no drive while reset is held
    a_r1_reset_no_drive: assert property (@(posedge clk)
        !rst_n |-> ((a_oe == '0) && (b_oe == '0)));
endmodule

// File: tb/test_bidir_latch_xcvr.sv
module test_bidir_latch_xcvr;
    localparam int HW = 18;
    localparam int NH = 2;
    localparam int W  = HW * NH;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          gang_i = 1'b0;
    logic [W-1:0]  a_in = '0, b_in = '0;
    logic [NH-1:0] ab_ce_n = '1, ab_le_n = '1, ab_oe_n = '1;
    logic [NH-1:0] ba_ce_n = '1, ba_le_n = '1, ba_oe_n = '1;
    logic [W-1:0]  a_out, b_out;
    logic [NH-1:0] a_oe, b_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    bidir_latch_xcvr #(.HALF_W(HW), .NUM_HALVES(NH)) i_bidir_latch_xcvr (
        .clk(clk), .rst_n(rst_n), .gang_i(gang_i),
        .a_in(a_in), .b_in(b_in),
        .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
        .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // inputs change at negedge, one posedge passes, sample 1 ns later
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        ab_ce_n = '1; ab_le_n = '1; ab_oe_n = '1;
        ba_ce_n = '1; ba_le_n = '1; ba_oe_n = '1;
    endtask

    task automatic load_both(logic [W-1:0] av, logic [W-1:0] bv);
        @(negedge clk);
        gang_i = 1'b0;
        a_in = av; b_in = bv;
        ab_ce_n = '0; ab_le_n = '0;
        ba_ce_n = '0; ba_le_n = '0;
        step();
        idle();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        a_in = 36'hF_FFFF_FFFF; b_in = 36'hF_FFFF_FFFF;
        ab_ce_n = '0; ab_le_n = '0; ab_oe_n = '0;
        ba_ce_n = '0; ba_le_n = '0; ba_oe_n = '0;
        step(); step();
        check("R1 b_out in reset", b_out, '0);
        check("R1 a_out in reset", a_out, '0);
        check("R1 flags in reset", {32'd0, a_oe, b_oe}, '0);
        idle();
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_transparent();
        @(negedge clk);
        a_in = 36'h1_2345_6789;
        ab_ce_n = '0; ab_le_n = '0;
        step();
        check("R2 load first word", b_out, 36'h1_2345_6789);
        @(negedge clk);
        a_in = 36'hA_5A5A_5A5A;
        step();
        check("R2 follow second word", b_out, 36'hA_5A5A_5A5A);
        idle();
    endtask

    task automatic t_hold();
        load_both(36'h3_3333_3333, 36'h0);
        @(negedge clk);
        a_in = 36'hC_CCCC_CCCC;
        ab_ce_n = '0; ab_le_n = '1;
        step();
        check("R3 hold after capture enable rise", b_out, 36'h3_3333_3333);
        @(negedge clk);
        ab_ce_n = '1; ab_le_n = '0;
        step();
        check("R3 hold after direction enable rise", b_out, 36'h3_3333_3333);
        idle();
    endtask

    task automatic t_drive();
        @(negedge clk);
        ab_ce_n = 2'b00; ab_oe_n = 2'b00;
        #1;
        check("R4 b_oe both on", {34'd0, b_oe}, 36'd3);
        ab_ce_n = 2'b10; ab_oe_n = 2'b01;
        #1;
        check("R4 b_oe needs both enables", {34'd0, b_oe}, 36'd0);
        ab_ce_n = 2'b10; ab_oe_n = 2'b00;
        #1;
        check("R4 b_oe half0 only", {34'd0, b_oe}, 36'd1);
        idle();
    endtask

    task automatic t_ba();
        @(negedge clk);
        b_in = 36'h9_8765_4321;
        ba_ce_n = '0; ba_le_n = '0; ba_oe_n = '0;
        step();
        check("R5 a_out loads b_in", a_out, 36'h9_8765_4321);
        check("R5 a_oe on", {34'd0, a_oe}, 36'd3);
        @(negedge clk);
        ba_le_n = '1; b_in = 36'h0_0000_0001;
        step();
        check("R5 a_out holds", a_out, 36'h9_8765_4321);
        idle();
    endtask

    task automatic t_indep();
        load_both(36'h1_1111_1111, 36'h2_2222_2222);
        @(negedge clk);
        a_in = 36'h7_7777_7777; b_in = 36'h8_8888_8888;
        ab_ce_n = '0; ab_le_n = '0; ab_oe_n = '0;
        step();
        check("R6 B-to-A bank untouched", a_out, 36'h2_2222_2222);
        check("R6 a_oe untouched", {34'd0, a_oe}, 36'd0);
        check("R6 A-to-B loaded", b_out, 36'h7_7777_7777);
        idle();
    endtask

    task automatic t_halves();
        load_both(36'h0_0000_0000, 36'h0);
        @(negedge clk);
        gang_i = 1'b0;
        a_in = 36'hF_FFFF_FFFF;
        ab_ce_n = 2'b10; ab_le_n = 2'b10;
        step();
        check("R7 only half0 loads", b_out, 36'h0_0003_FFFF);
        @(negedge clk);
        a_in = 36'h5_5555_5555;
        ab_ce_n = 2'b01; ab_le_n = 2'b01;
        step();
        check("R7 only half1 loads", b_out, {18'h15555, 18'h3FFFF});
        idle();
    endtask

    task automatic t_gang();
        load_both(36'h0, 36'h0);
        @(negedge clk);
        gang_i = 1'b1;
        a_in = 36'hD_EAD0_BEEF;
        ab_ce_n = 2'b10; ab_le_n = 2'b10; ab_oe_n = 2'b10;
        #1;
        check("R8 gang flags follow half0", {34'd0, b_oe}, 36'd3);
        step();
        check("R8 gang loads whole word", b_out, 36'hD_EAD0_BEEF);
        @(negedge clk);
        a_in = 36'h1_0101_0101;
        ab_ce_n = 2'b01; ab_le_n = 2'b01; ab_oe_n = 2'b01;
        #1;
        check("R8 half1 controls ignored flags", {34'd0, b_oe}, 36'd0);
        step();
        check("R8 half1 controls ignored data", b_out, 36'hD_EAD0_BEEF);
        idle();
        gang_i = 1'b0;
    endtask

    task automatic t_reenable();
        load_both(36'h4_2424_2424, 36'h6_1616_1616);
        @(negedge clk);
        ab_ce_n = '0; ab_oe_n = '0;
        step();
        @(negedge clk);
        ab_oe_n = '1;
        step();
        check("R9 flag drops", {34'd0, b_oe}, 36'd0);
        @(negedge clk);
        ab_oe_n = '0;
        step();
        check("R9 flag back", {34'd0, b_oe}, 36'd3);
        check("R9 word kept", b_out, 36'h4_2424_2424);
        idle();
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_transparent();
        t_hold();
        t_drive();
        t_ba();
        t_indep();
        t_halves();
        t_gang();
        t_reenable();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule